// File: doc/BRIEF.md
# Grouped Programmable Interrupt Priority Resolver

This block picks one winner among six interrupt request lines. A line competes when its pending bit and its enable bit are both set. The six lines are arranged in three fixed pairs. A programmable priority register sets two things: the rank of the three pairs against each other, and, for each pair, which of its two members goes first. The winner is the highest-ranked competing line in this two-level order. The block reports it as a valid flag and a 3-bit line index.

The priority register is write-only from the block's edge. It loads on a write strobe and resets to zero. Zero is a reserved group-order code, so no winner is reported until software programs a legal order. The result is held in a register and recomputed every cycle. The outputs are plain status with no handshake, so the block applies no back-pressure; a consumer simply samples them.

Top module: `irq_prio_resolver`

## Requirements
- R1: The lines are paired as follows: pair A holds lines 3 and 5, pair B holds lines 0 and 2, and pair C holds lines 1 and 4. Both members of a pair always sit next to each other in the overall order.
- R2: Priority register bits 2:0 rank the pairs, highest first: 001 gives C, A, B; 010 gives A, B, C; 011 gives A, C, B; 100 gives B, C, A; 101 gives C, B, A; 110 gives B, A, C.
- R3: With order code 000 or 111 in bits 2:0, win_valid is low and win_idx is 0, whatever lines are requesting.
- R4: Priority register bit 3 orders pair C: 0 puts line 1 ahead of line 4, and 1 puts line 4 ahead of line 1.
- R5: Priority register bit 4 orders pair B: 0 puts line 2 ahead of line 0, and 1 puts line 0 ahead of line 2.
- R6: Priority register bit 5 orders pair A: 0 puts line 5 ahead of line 3, and 1 puts line 3 ahead of line 5.
- R7: A line competes only when both its pending and enable bits are 1. When no line competes, win_valid is 0 and win_idx is 0. When win_valid is 1, win_idx names a line that was competing.
- R8: A change on the request inputs shows on the outputs after exactly one rising clock edge. A value written to the priority register at one edge steers the result produced at the following edge.
- R9: While reset is asserted, the priority register is 0, win_valid is 0 and win_idx is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Write strobe for the priority register |
| cfg_wr_data | input | 6 | Priority register value: [2:0] pair order, [3] pair C swap, [4] pair B swap, [5] pair A swap |
| req_pending | input | 6 | Pending bit per request line |
| req_enable | input | 6 | Enable bit per request line |
| win_valid | output | 1 | A winner exists |
| win_idx | output | 3 | Index of the winning line, 0 when there is no winner |

## Verification
The hardest case to reach is a competition that the within-pair swap bit decides. That needs both members of the top-ranked pair competing together, under every order code, and with either polarity of that pair's swap bit. The bench reaches it by sweeping all 64 register values against all 64 competing-line patterns. For each pattern it splits the competing set differently between pending and enable, so lines that are pending but disabled, or enabled but not pending, also appear. Directed steps sample the outputs just before and just after a clock edge, which exposes the one-edge delay on requests and on register writes.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam int NUM_REQ = 6;
  localparam int NUM_GRP = 3;
  localparam int IDX_W   = $clog2(NUM_REQ);
  localparam int ORDER_W = 3;
  localparam int CFG_W   = ORDER_W + NUM_GRP;

  // Encoding doubles as the bit slot of each pair's swap flag above the order field.
  typedef enum logic [1:0] {
    GRP_C = 2'd0,
    GRP_B = 2'd1,
    GRP_A = 2'd2
  } grp_e;

  typedef struct packed {
    logic [NUM_GRP-1:0] swap;   // swap[GRP_C]=bit3, swap[GRP_B]=bit4, swap[GRP_A]=bit5
    logic [ORDER_W-1:0] order;
  } prio_cfg_t;

  typedef struct packed {
    logic             valid;
    logic [IDX_W-1:0] idx;
  } win_t;

  typedef struct packed {
    logic                    reserved;
    grp_e [NUM_GRP-1:0]      seq;      // seq[0] is the top-ranked pair
  } grp_rank_t;

  // Member that leads its pair when the swap flag is clear.
  function automatic int pair_lead(input int g);
    case (g)
      0:       return 1;   // pair C
      1:       return 2;   // pair B
      default: return 5;   // pair A
    endcase
  endfunction

  // Member that leads its pair when the swap flag is set.
  function automatic int pair_trail(input int g);
    case (g)
      0:       return 4;
      1:       return 0;
      default: return 3;
    endcase
  endfunction

  function automatic grp_rank_t decode_order(input logic [ORDER_W-1:0] code);
    grp_rank_t r;
    r.reserved = 1'b0;
    r.seq[0]   = GRP_A;
    r.seq[1]   = GRP_B;
    r.seq[2]   = GRP_C;
    case (code)
      3'b001: begin r.seq[0] = GRP_C; r.seq[1] = GRP_A; r.seq[2] = GRP_B; end
      3'b010: begin r.seq[0] = GRP_A; r.seq[1] = GRP_B; r.seq[2] = GRP_C; end
      3'b011: begin r.seq[0] = GRP_A; r.seq[1] = GRP_C; r.seq[2] = GRP_B; end
      3'b100: begin r.seq[0] = GRP_B; r.seq[1] = GRP_C; r.seq[2] = GRP_A; end
      3'b101: begin r.seq[0] = GRP_C; r.seq[1] = GRP_B; r.seq[2] = GRP_A; end
      3'b110: begin r.seq[0] = GRP_B; r.seq[1] = GRP_A; r.seq[2] = GRP_C; end
      default: r.reserved = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/irq_prio_cfg.sv
module irq_prio_cfg
  import irq_prio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output prio_cfg_t        cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q <= prio_cfg_t'(wr_data);
    end
  end

endmodule

// File: rtl/irq_pair_arb.sv
module irq_pair_arb
  import irq_prio_pkg::*;
#(
  parameter int LEAD_IDX  = 1,
  parameter int TRAIL_IDX = 4
) (
  input  logic [1:0] pair_act,   // [0] lead member, [1] trail member
  input  logic       swap,
  output win_t       win
);

  localparam logic [IDX_W-1:0] LEAD_V  = IDX_W'(LEAD_IDX);
  localparam logic [IDX_W-1:0] TRAIL_V = IDX_W'(TRAIL_IDX);

  logic             first_act, second_act;
  logic [IDX_W-1:0] first_idx, second_idx;

  always_comb begin
    first_act  = swap ? pair_act[1] : pair_act[0];
    second_act = swap ? pair_act[0] : pair_act[1];
    first_idx  = swap ? TRAIL_V : LEAD_V;
    second_idx = swap ? LEAD_V : TRAIL_V;
    win = '0;
    if (first_act) begin
      win.valid = 1'b1;
      win.idx   = first_idx;
    end else if (second_act) begin
      win.valid = 1'b1;
      win.idx   = second_idx;
    end
  end

endmodule

// File: rtl/irq_grp_sel.sv
module irq_grp_sel
  import irq_prio_pkg::*;
(
  input  win_t [NUM_GRP-1:0] grp_win,
  input  logic [ORDER_W-1:0] order,
  output win_t               win
);

  grp_rank_t rank;

  always_comb begin
    rank = decode_order(order);
    win  = '0;
    if (!rank.reserved) begin
      // Walk from lowest to highest rank so the top-ranked pair overrides.
      for (int r = NUM_GRP - 1; r >= 0; r--) begin
        if (grp_win[rank.seq[r]].valid) begin
          win = grp_win[rank.seq[r]];
        end
      end
    end
  end

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_prio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [CFG_W-1:0]   cfg_wr_data,
  input  logic [NUM_REQ-1:0] req_pending,
  input  logic [NUM_REQ-1:0] req_enable,
  output logic               win_valid,
  output logic [IDX_W-1:0]   win_idx
);

  prio_cfg_t          prio_cfg_q;
  logic [NUM_REQ-1:0] active;
  win_t [NUM_GRP-1:0] grp_win;
  win_t               win_d;
  win_t               win_q;

  irq_prio_cfg cfg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .cfg_q   (prio_cfg_q)
  );

  assign active = req_pending & req_enable;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_pair
    localparam int LEAD  = pair_lead(g);
    localparam int TRAIL = pair_trail(g);

    irq_pair_arb #(
      .LEAD_IDX  (LEAD),
      .TRAIL_IDX (TRAIL)
    ) arb_i (
      .pair_act ({active[TRAIL], active[LEAD]}),
      .swap     (prio_cfg_q.swap[g]),
      .win      (grp_win[g])
    );
  end

  irq_grp_sel sel_i (
    .grp_win (grp_win),
    .order   (prio_cfg_q.order),
    .win     (win_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else begin
      win_q <= win_d;
    end
  end

  assign win_valid = win_q.valid;
  assign win_idx   = win_q.idx;

endmodule

// File: rtl/irq_prio_checker.sv
module irq_prio_checker
  import irq_prio_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_REQ-1:0] req_pending,
  input logic [NUM_REQ-1:0] req_enable,
  input logic               win_valid,
  input logic [IDX_W-1:0]   win_idx,
  input prio_cfg_t          prio_cfg
);

  logic [NUM_REQ-1:0] act_now;
  logic [NUM_REQ-1:0] act_prev;
  logic               order_bad;

  assign act_now   = req_pending & req_enable;
  assign order_bad = (prio_cfg.order == 3'b000) || (prio_cfg.order == 3'b111);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_prev <= '0;
    else        act_prev <= act_now;
  end

  p_reserved_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    order_bad |=> (!win_valid && win_idx == '0));

  p_idle_when_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_now == '0) |=> (!win_valid && win_idx == '0));

  p_winner_competed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (((act_prev >> win_idx) & 6'd1) != '0));

  p_one_edge_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_now != '0) && !order_bad) |=> win_valid);

  always_comb begin
    if (rst_n == 1'b0) begin
      p_reset_clear_r9: assert (prio_cfg == '0 && !win_valid && win_idx == '0);
    end
  end

endmodule

bind irq_prio_resolver irq_prio_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_pending (req_pending),
  .req_enable  (req_enable),
  .win_valid   (win_valid),
  .win_idx     (win_idx),
  .prio_cfg    (prio_cfg_q)
);

// File: tb/irq_prio_resolver_tb_top.sv
module irq_prio_resolver_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [5:0] cfg_wr_data = '0;
  logic [5:0] req_pending = '0;
  logic [5:0] req_enable = '0;
  logic       win_valid;
  logic [2:0] win_idx;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  irq_prio_resolver dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .req_pending (req_pending),
    .req_enable  (req_enable),
    .win_valid   (win_valid),
    .win_idx     (win_idx)
  );

  // Reference model: rank = pair position * 2 + position inside the pair.
  function automatic int exp_winner(input int cfg, input int act);
    int ord, best, best_score, pa, pb, pc, sa, sb, sc, gp, mp, score;
    ord = cfg & 7;
    sc = (cfg >> 3) & 1;
    sb = (cfg >> 4) & 1;
    sa = (cfg >> 5) & 1;
    case (ord)
      1: begin pc = 0; pa = 1; pb = 2; end
      2: begin pa = 0; pb = 1; pc = 2; end
      3: begin pa = 0; pc = 1; pb = 2; end
      4: begin pb = 0; pc = 1; pa = 2; end
      5: begin pc = 0; pb = 1; pa = 2; end
      6: begin pb = 0; pa = 1; pc = 2; end
      default: return -1;
    endcase
    best = -1;
    best_score = 99;
    for (int i = 0; i < 6; i++) begin
      if (((act >> i) & 1) != 0) begin
        case (i)
          0: begin gp = pb; mp = 1 - sb; end
          2: begin gp = pb; mp = sb;     end
          1: begin gp = pc; mp = sc;     end
          4: begin gp = pc; mp = 1 - sc; end
          3: begin gp = pa; mp = 1 - sa; end
          default: begin gp = pa; mp = sa; end
        endcase
        score = gp * 2 + mp;
        if (score < best_score) begin
          best_score = score;
          best = i;
        end
      end
    end
    return best;
  endfunction

  task automatic check(input string req, input int exp_v, input int exp_i);
    n_checks++;
    if (win_valid !== exp_v[0] || win_idx !== exp_i[2:0]) begin
      n_fails++;
      $display("FAIL %s: got valid=%0d idx=%0d, expected valid=%0d idx=%0d",
               req, win_valid, win_idx, exp_v, exp_i);
    end
  endtask

  task automatic check_exp(input string req, input int w);
    if (w < 0) check(req, 0, 0);
    else       check(req, 1, w);
  endtask

  task automatic write_cfg(input logic [5:0] v);
    @(negedge clk);
    cfg_wr_en   = 1'b1;
    cfg_wr_data = v;
    @(posedge clk);
    @(negedge clk);
    cfg_wr_en   = 1'b0;
  endtask

  function automatic string sweep_tag(input int cfg, input int act, input int w);
    int ord;
    ord = cfg & 7;
    if (ord == 0 || ord == 7) return "R3";
    if (act == 0)             return "R7";
    if ((w == 1 || w == 4) && ((act & 6'h12) == 6'h12)) return "R4";
    if ((w == 0 || w == 2) && ((act & 6'h05) == 6'h05)) return "R5";
    if ((w == 3 || w == 5) && ((act & 6'h28) == 6'h28)) return "R6";
    return "R1 R2";
  endfunction

  initial begin
    int w;
    // Reset state under full request load (R9).
    req_pending = 6'h3f;
    req_enable  = 6'h3f;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", 0, 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R9 R3", 0, 0);

    // Request latency (R8): order A,B,C with no swaps.
    write_cfg(6'b000_010);
    req_pending = 6'b000010;
    req_enable  = 6'h3f;
    @(posedge clk);
    @(negedge clk);
    check("R8", 1, 1);
    req_pending = 6'b100000;
    #1;
    check("R8", 1, 1);
    @(posedge clk);
    @(negedge clk);
    check("R8", 1, 5);

    // Register write latency (R8): lines 1 and 5 compete.
    req_pending = 6'b100010;
    @(posedge clk);
    @(negedge clk);
    check("R8", 1, 5);
    cfg_wr_en   = 1'b1;
    cfg_wr_data = 6'b000_001;
    @(posedge clk);
    @(negedge clk);
    cfg_wr_en = 1'b0;
    check("R8", 1, 5);
    @(posedge clk);
    @(negedge clk);
    check("R8", 1, 1);

    // Exhaustive sweep of register values and competing sets.
    for (int cfg = 0; cfg < 64; cfg++) begin
      write_cfg(6'(cfg));
      for (int act = 0; act < 64; act++) begin
        logic [5:0] m;
        m = 6'((act * 7 + cfg * 13) & 63);
        req_pending = 6'(act) | m;
        req_enable  = 6'(act) | (~m);
        @(posedge clk);
        @(negedge clk);
        w = exp_winner(cfg, act);
        check_exp(sweep_tag(cfg, act, w), w);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule